// File: doc/BRIEF.md
# Power-Line Hum Clock Recovery Loop with Seconds Pulse

This block takes the zero-crossing pulses that a front end cuts out of 50/60 Hz mains hum and turns them into a steady clock. The pulses are noisy and jittery and can stop for a while. The block samples the raw pulse line only on a sample-enable tick of about 32 kHz. It keeps a local cycle counter whose length, in ticks, is steered by an integer proportional-integral loop. Every rising input edge is compared with the point where the local counter wraps. An edge that lands too far from that point is thrown away. An accepted edge nudges the local cycle length by one tick at most.

A divider counts local cycles and drives a square seconds pulse with even duty. A lock monitor drives a fault flag. The flag is high after reset. It drops once enough edges in a row land close to the local wrap. It rises again when edges keep landing far off or when the input goes quiet for too long. While the input is quiet, the local counter keeps running at its last length. Missing edges are therefore filled in from the local counter. The cycle length in use and the last measured phase error are brought out for debug.

Top module: `hum_pps_pll`

## Requirements
- R1: After reset, `err_o` is 1, `pps_o` is 0, `dbg_period_o` equals NOM_PERIOD (533) and `dbg_phase_err_o` is 0.
- R2: State advances only on cycles with `tick_i` high. An input edge is a tick on which `pulse_i` is 1 and was 0 on the previous tick. A pulse that rises and falls while `tick_i` is low is not seen, and the local counter does not move.
- R3: The local counter runs from 0 to period-1. For an edge seen while the counter holds c, the phase error is c when c < period/2 (rounded down), and c - period otherwise. This value is saturated to plus or minus period/2. A positive value means the input is late. It appears on `dbg_phase_err_o` one clock after each detected edge.
- R4: An edge whose phase error magnitude is greater than WINDOW (48) is rejected and leaves the period unchanged.
- R5: On an accepted edge, the integrator adds the phase error and is clamped to plus or minus INT_LIMIT. The control term is (error >>> KP_SHIFT) + (integrator >>> KI_SHIFT), with shifts 2 and 4. The period moves by +1, -1 or 0 according to the sign of the control term, never by more.
- R6: The period stays between NOM_PERIOD - NOM_PERIOD/50 and NOM_PERIOD + NOM_PERIOD/50, which is 523 to 543.
- R7: With no accepted edge, the period holds and the local counter keeps wrapping at that period. An edge arriving after a dropout is measured against the reconstructed cycles.
- R8: `pps_o` starts low and toggles on every PPS_HALF-th (30th) local wrap.
- R9: `err_o` falls on the LOCK_EDGES-th (4th) consecutive accepted edge with error magnitude at most LOCK_THRESH (16).
- R10: `err_o` rises on the LOSS_EDGES-th (4th) consecutive detected edge that is either rejected or has error magnitude above LOCK_THRESH.
- R11: `err_o` rises when DROP_TICKS (2132) ticks pass after the last detected edge with no new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Sample enable, one clock wide, about 32 kHz |
| pulse_i | input | 1 | Raw zero-crossing pulse from the front end |
| pps_o | output | 1 | Seconds pulse with even duty |
| err_o | output | 1 | Loss-of-lock or loss-of-input flag |
| dbg_period_o | output | CNT_W (10) | Local cycle length in ticks |
| dbg_phase_err_o | output | ERR_W (11) | Signed phase error of the last detected edge |

## Verification
The bench places edges at exact counter values on both sides of the wrap. This covers the window edge at 48 against 49 and the saturation point at half a period. A wrong sign convention would move the period the wrong way. An off-by-one window would accept the edge at 49. A large error pushes the control term far past one. A design that scaled its step would then jump the period by several ticks instead of one.

Repeated late edges and repeated early edges, spaced at the local cycle, drive the period into both clamps. Lock is gained and lost on exactly the fourth qualifying edge. The dropout flag must rise on exactly tick 2132. A later edge must still measure a small error, which shows that the cycles were reconstructed during the gap. A divider that counted ticks instead of wraps would move the seconds-pulse edges, and so would one that ignored the sample enable.

// File: rtl/hum_pll_pkg.sv
package hum_pll_pkg;

  // Signed distance of a counter value from the nearest wrap point,
  // saturated to +/- half a cycle. Positive: the input came late.
  function automatic int wrap_gap(input int cnt, input int per);
    int half;
    int d;
    half = per / 2;
    d = (cnt < half) ? cnt : cnt - per;
    if (d > half)  d = half;
    if (d < -half) d = -half;
    return d;
  endfunction

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Sign of the PI control term: the period moves by this many ticks.
  function automatic int pi_quantum(input int e, input int acc, input int kp_sh, input int ki_sh);
    int c;
    c = (e >>> kp_sh) + (acc >>> ki_sh);
    if (c > 0) return 1;
    if (c < 0) return -1;
    return 0;
  endfunction

endpackage

// File: rtl/hum_edge_sense.sv
module hum_edge_sense (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic pulse_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       prev_q <= 1'b0;
    else if (tick_i) prev_q <= pulse_i;
  end

  assign edge_o = tick_i & pulse_i & ~prev_q;
endmodule

// File: rtl/hum_phase_loop.sv
module hum_phase_loop #(
  parameter int unsigned NOM_PERIOD = 533,
  parameter int unsigned PER_DEV    = 10,
  parameter int unsigned WINDOW     = 48,
  parameter int unsigned KP_SHIFT   = 2,
  parameter int unsigned KI_SHIFT   = 4,
  parameter int unsigned INT_LIMIT  = 256,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned ERR_W      = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    tick_i,
  input  logic                    edge_i,
  output logic                    accept_o,
  output logic                    wrap_o,
  output logic signed [ERR_W-1:0] meas_o,
  output logic signed [ERR_W-1:0] err_q_o,
  output logic [CNT_W-1:0]        period_o
);
  import hum_pll_pkg::*;

  localparam int unsigned ACC_W = $clog2(INT_LIMIT + 1) + 1;
  localparam int P_LO = int'(NOM_PERIOD) - int'(PER_DEV);
  localparam int P_HI = int'(NOM_PERIOD) + int'(PER_DEV);

  logic [CNT_W-1:0]        ph_q, per_q, per_nx;
  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic signed [ERR_W-1:0] err_q;
  int meas_int, acc_int, step_int;

  always_comb begin
    meas_int = wrap_gap(int'(ph_q), int'(per_q));
    acc_int  = clamp_int(int'(acc_q) + meas_int, -int'(INT_LIMIT), int'(INT_LIMIT));
    step_int = pi_quantum(meas_int, acc_int, int'(KP_SHIFT), int'(KI_SHIFT));
    acc_nx   = ACC_W'(acc_int);
    per_nx   = CNT_W'(clamp_int(int'(per_q) + step_int, P_LO, P_HI));
  end

  assign meas_o   = ERR_W'(meas_int);
  assign accept_o = edge_i & (mag(meas_int) <= int'(WINDOW));
  // >= keeps the counter bounded when the period shrinks under it
  assign wrap_o   = tick_i & (ph_q >= per_q - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q  <= '0;
      per_q <= CNT_W'(NOM_PERIOD);
      acc_q <= '0;
      err_q <= '0;
    end else if (tick_i) begin
      ph_q <= wrap_o ? '0 : ph_q + CNT_W'(1);
      if (edge_i) err_q <= meas_o;
      if (accept_o) begin
        acc_q <= acc_nx;
        per_q <= per_nx;
      end
    end
  end

  assign err_q_o  = err_q;
  assign period_o = per_q;
endmodule

// File: rtl/hum_pps_div.sv
module hum_pps_div #(
  parameter int unsigned PPS_HALF = 30
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wrap_i,
  output logic pps_o
);
  localparam int unsigned C_W = $clog2(PPS_HALF + 1);

  logic [C_W-1:0] cyc_q;
  logic           pps_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cyc_q <= '0;
      pps_q <= 1'b0;
    end else if (wrap_i) begin
      if (cyc_q == C_W'(PPS_HALF - 1)) begin
        cyc_q <= '0;
        pps_q <= ~pps_q;
      end else begin
        cyc_q <= cyc_q + C_W'(1);
      end
    end
  end

  assign pps_o = pps_q;
endmodule

// File: rtl/hum_lock_mon.sv
module hum_lock_mon #(
  parameter int unsigned ERR_W       = 11,
  parameter int unsigned LOCK_THRESH = 16,
  parameter int unsigned LOCK_EDGES  = 4,
  parameter int unsigned LOSS_EDGES  = 4,
  parameter int unsigned DROP_TICKS  = 2132
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    tick_i,
  input  logic                    edge_i,
  input  logic                    accept_i,
  input  logic signed [ERR_W-1:0] meas_i,
  output logic                    drop_o,
  output logic                    err_o
);
  import hum_pll_pkg::*;

  localparam int unsigned G_W = $clog2(LOCK_EDGES + 1);
  localparam int unsigned B_W = $clog2(LOSS_EDGES + 1);
  localparam int unsigned D_W = $clog2(DROP_TICKS + 1);

  logic [G_W-1:0] good_q;
  logic [B_W-1:0] bad_q;
  logic [D_W-1:0] gap_q;
  logic           flag_q;
  logic           close;

  assign close  = accept_i & (mag(int'(meas_i)) <= int'(LOCK_THRESH));
  assign drop_o = tick_i & ~edge_i & (gap_q == D_W'(DROP_TICKS - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      good_q <= '0;
      bad_q  <= '0;
      gap_q  <= '0;
      flag_q <= 1'b1;
    end else if (tick_i) begin
      if (edge_i) begin
        gap_q <= '0;
        if (close) begin
          bad_q <= '0;
          if (good_q == G_W'(LOCK_EDGES - 1)) flag_q <= 1'b0;
          else                                good_q <= good_q + G_W'(1);
        end else begin
          good_q <= '0;
          if (bad_q == B_W'(LOSS_EDGES - 1)) flag_q <= 1'b1;
          else                               bad_q  <= bad_q + B_W'(1);
        end
      end else begin
        if (gap_q != D_W'(DROP_TICKS - 1)) gap_q <= gap_q + D_W'(1);
        if (drop_o) begin
          flag_q <= 1'b1;
          good_q <= '0;
        end
      end
    end
  end

  assign err_o = flag_q;
endmodule

// File: rtl/hum_pps_pll.sv
module hum_pps_pll #(
  parameter int unsigned NOM_PERIOD  = 533,
  parameter int unsigned PPS_HALF    = 30,
  parameter int unsigned WINDOW      = 48,
  parameter int unsigned LOCK_THRESH = 16,
  parameter int unsigned LOCK_EDGES  = 4,
  parameter int unsigned LOSS_EDGES  = 4,
  parameter int unsigned DROP_TICKS  = 2132,
  parameter int unsigned KP_SHIFT    = 2,
  parameter int unsigned KI_SHIFT    = 4,
  parameter int unsigned INT_LIMIT   = 256,
  localparam int unsigned PER_DEV    = NOM_PERIOD / 50,
  localparam int unsigned CNT_W      = $clog2(NOM_PERIOD + PER_DEV + 1),
  localparam int unsigned ERR_W      = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    tick_i,
  input  logic                    pulse_i,
  output logic                    pps_o,
  output logic                    err_o,
  output logic [CNT_W-1:0]        dbg_period_o,
  output logic signed [ERR_W-1:0] dbg_phase_err_o
);
  logic                    edge_det, edge_ok, lcl_wrap, drop_hit;
  logic signed [ERR_W-1:0] meas;

  hum_edge_sense i_sense (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .pulse_i(pulse_i), .edge_o(edge_det)
  );

  hum_phase_loop #(
    .NOM_PERIOD(NOM_PERIOD), .PER_DEV(PER_DEV), .WINDOW(WINDOW), .KP_SHIFT(KP_SHIFT),
    .KI_SHIFT(KI_SHIFT), .INT_LIMIT(INT_LIMIT), .CNT_W(CNT_W), .ERR_W(ERR_W)
  ) i_loop (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .edge_i(edge_det),
    .accept_o(edge_ok), .wrap_o(lcl_wrap), .meas_o(meas),
    .err_q_o(dbg_phase_err_o), .period_o(dbg_period_o)
  );

  hum_pps_div #(.PPS_HALF(PPS_HALF)) i_div (
    .clk_i(clk_i), .rst_i(rst_i), .wrap_i(lcl_wrap), .pps_o(pps_o)
  );

  hum_lock_mon #(
    .ERR_W(ERR_W), .LOCK_THRESH(LOCK_THRESH), .LOCK_EDGES(LOCK_EDGES),
    .LOSS_EDGES(LOSS_EDGES), .DROP_TICKS(DROP_TICKS)
  ) i_mon (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .edge_i(edge_det),
    .accept_i(edge_ok), .meas_i(meas), .drop_o(drop_hit), .err_o(err_o)
  );
endmodule

// File: rtl/hum_pps_pll_chk.sv
module hum_pps_pll_chk #(
  parameter int unsigned P_MIN = 523,
  parameter int unsigned P_MAX = 543,
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_i,
  input logic             pps_o,
  input logic             err_o,
  input logic             edge_det,
  input logic             edge_ok,
  input logic             lcl_wrap,
  input logic             drop_hit,
  input logic [CNT_W-1:0] dbg_period_o
);
  p_period_range_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (dbg_period_o >= CNT_W'(P_MIN)) && (dbg_period_o <= CNT_W'(P_MAX)));

  p_one_quantum_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (({1'b0, dbg_period_o} <= {1'b0, $past(dbg_period_o)} + 1'b1) &&
              ({1'b0, dbg_period_o} + 1'b1 >= {1'b0, $past(dbg_period_o)})));

  p_reject_holds_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (edge_det && !edge_ok) |=> $stable(dbg_period_o));

  p_coast_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !edge_ok |=> $stable(dbg_period_o));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> ($stable(dbg_period_o) && $stable(pps_o) && $stable(err_o)));

  p_pps_on_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !lcl_wrap |=> $stable(pps_o));

  p_dropout_flag_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    drop_hit |=> err_o);
endmodule

bind hum_pps_pll hum_pps_pll_chk #(
  .P_MIN(NOM_PERIOD - PER_DEV), .P_MAX(NOM_PERIOD + PER_DEV), .CNT_W(CNT_W)
) i_chk (
  .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .pps_o(pps_o), .err_o(err_o),
  .edge_det(edge_det), .edge_ok(edge_ok), .lcl_wrap(lcl_wrap), .drop_hit(drop_hit),
  .dbg_period_o(dbg_period_o)
);

// File: tb/test_hum_pps_pll.sv
module test_hum_pps_pll;
  localparam int NOM = 533;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, pulse = 1'b0;
  logic pps, errf;
  logic [9:0] per;
  logic signed [10:0] perr;
  int kpos = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hum_pps_pll i_hum_pps_pll (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .pulse_i(pulse),
    .pps_o(pps), .err_o(errf), .dbg_period_o(per), .dbg_phase_err_o(perr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    if (n > 0) begin
      for (int i = 0; i < n; i++) begin
        @(posedge clk);
        kpos++;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; pulse = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    kpos = 0;
  endtask

  // pulse seen by posedge number e; returns at the negedge after it
  task automatic edge_at(input int e);
    clk_n(e - kpos);
    pulse = 1'b1;
    clk_n(1);
    pulse = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(errf == 1'b1, "R1 err", int'(errf), 1);
    chk(pps == 1'b0, "R1 pps", int'(pps), 0);
    chk(int'(per) == NOM, "R1 period", int'(per), NOM);
    chk(int'(perr) == 0, "R1 phase", int'(perr), 0);
  endtask

  task automatic t_tick_gate();
    int k0;
    do_reset();
    tick = 1'b0;
    clk_n(50); pulse = 1'b1; clk_n(2); pulse = 1'b0; clk_n(2);
    chk(int'(perr) == 0, "R2 no edge without tick", int'(perr), 0);
    chk(int'(per) == NOM, "R2 period idle", int'(per), NOM);
    tick = 1'b1;
    k0 = kpos;
    edge_at(k0 + 8);
    chk(int'(perr) == 8, "R2 counter held while idle", int'(perr), 8);
    chk(int'(per) == NOM + 1, "R5 late edge lengthens", int'(per), NOM + 1);
  endtask

  task automatic t_early();
    do_reset();
    edge_at(NOM - 8);
    chk(int'(perr) == -8, "R3 early sign", int'(perr), -8);
    chk(int'(per) == NOM - 1, "R5 early edge shortens", int'(per), NOM - 1);
  endtask

  task automatic t_quantum();
    do_reset();
    edge_at(40);
    chk(int'(per) == NOM + 1, "R5 one quantum", int'(per), NOM + 1);
  endtask

  task automatic t_window();
    do_reset();
    edge_at(100);
    chk(int'(perr) == 100, "R4 far edge measured", int'(perr), 100);
    chk(int'(per) == NOM, "R4 far edge ignored", int'(per), NOM);
    edge_at(NOM + 49);
    chk(int'(per) == NOM, "R4 window+1 ignored", int'(per), NOM);
    edge_at(2 * NOM + 48);
    chk(int'(per) == NOM + 1, "R4 window edge accepted", int'(per), NOM + 1);
  endtask

  task automatic t_saturate();
    do_reset();
    edge_at(266);
    chk(int'(perr) == -266, "R3 saturate low", int'(perr), -266);
    edge_at(NOM + 265);
    chk(int'(perr) == 265, "R3 half minus one", int'(perr), 265);
    chk(int'(per) == NOM, "R4 both rejected", int'(per), NOM);
  endtask

  task automatic t_bounds();
    int e, p, pn;
    do_reset();
    e = 20; p = NOM;
    for (int i = 0; i < 14; i++) begin
      edge_at(e);
      chk(int'(perr) == 20, "R3 steady late", int'(perr), 20);
      p = (p + 1 > 543) ? 543 : p + 1;
      chk(int'(per) == p, "R6 upper clamp", int'(per), p);
      e += p;
    end
    do_reset();
    e = NOM - 20; p = NOM;
    for (int i = 0; i < 14; i++) begin
      edge_at(e);
      chk(int'(perr) == -20, "R3 steady early", int'(perr), -20);
      pn = (p - 1 < 523) ? 523 : p - 1;
      chk(int'(per) == pn, "R6 lower clamp", int'(per), pn);
      e += 2 * pn - p;
      p = pn;
    end
  endtask

  task automatic t_lock();
    int e, p;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      edge_at(NOM * (i + 1));
      chk(errf == (i < 3), "R9 lock on 4th good edge", int'(errf), int'(i < 3));
    end
    e = 4 * NOM + 30; p = NOM;
    for (int i = 0; i < 4; i++) begin
      edge_at(e);
      p++;
      chk(errf == (i == 3), "R10 loss on 4th bad edge", int'(errf), int'(i == 3));
      e += p;
    end
  endtask

  task automatic t_dropout();
    int k;
    do_reset();
    for (int i = 0; i < 4; i++) edge_at(NOM * (i + 1));
    k = 4 * NOM;
    chk(errf == 1'b0, "R9 locked", int'(errf), 0);
    clk_n(k + 2132 - kpos);
    chk(errf == 1'b0, "R11 before timeout", int'(errf), 0);
    clk_n(1);
    chk(errf == 1'b1, "R11 timeout", int'(errf), 1);
    chk(int'(per) == NOM, "R7 period held", int'(per), NOM);
    edge_at(k + 5 * NOM + 5);
    chk(int'(perr) == 5, "R7 cycles reconstructed", int'(perr), 5);
  endtask

  task automatic t_pps();
    do_reset();
    clk_n(15989);
    chk(pps == 1'b0, "R8 before 30th wrap", int'(pps), 0);
    clk_n(1);
    chk(pps == 1'b1, "R8 rise at 30th wrap", int'(pps), 1);
    clk_n(31979 - kpos);
    chk(pps == 1'b1, "R8 before 60th wrap", int'(pps), 1);
    clk_n(1);
    chk(pps == 1'b0, "R8 fall at 60th wrap", int'(pps), 0);
  endtask

  initial begin
    t_reset();
    t_tick_gate();
    t_early();
    t_quantum();
    t_window();
    t_saturate();
    t_bounds();
    t_lock();
    t_dropout();
    t_pps();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule